// File: doc/BRIEF.md
# Wiper Position Register with One-Hot Tap Select

This block keeps a 6-bit volatile wiper position for each of several digitally controlled resistor ladders and turns each position into a one-hot enable for the 64 tap switches of that ladder. Code 0 selects the switch at the low end of the ladder and code 63 selects the switch at the high end.

A position can be changed in four ways:
- a direct write of a host-supplied value;
- a transfer from one of the pot's stored data registers;
- a global transfer in which every pot loads at the same time from its own data register at the same slot;
- a single step up or down.

While reset is held, each position is recalled from data register slot 0 of its pot, which models the recall at power-up. The position register keeps no value across a reset, and the stored data register contents are inputs to this block. The tap select is registered, so it follows the position one clock later and changes only at a clock edge.

Top module: `wiper_tap_reg`

## Requirements
- R1: While `rst_n` is low, at every clock edge each pot's `wiper_pos` field loads the value of that pot's data register slot 0. The slot is `dr_bank[(p*4+0)*6 +: 6]`. At the same edge `tap_sel` loads the one-hot code of that value.
- R2: Once the first clock edge has passed, each pot's 64-bit `tap_sel` field has exactly one bit set.
- R3: Outside reset, a pot's `tap_sel` field equals `1 << wiper_pos` as it stood one clock earlier. Bit 0 is the low-end switch (code 00h) and bit 63 is the high-end switch (code 3Fh).
- R4: When `wr_en[p]` is high, pot p loads `wr_data` at the next clock edge.
- R5: When `xfr_en[p]` is high and `wr_en[p]` is low, pot p loads its data register slot `xfr_sel`. That slot is `dr_bank[(p*4+xfr_sel)*6 +: 6]`.
- R6: When `xfr_all` is high, every pot whose `wr_en` bit is low loads its own slot `xfr_sel` at the same edge.
- R7: When `step_en[p]` is high and no load is pending for pot p, the position rises by 1 if `step_up` is 1 and falls by 1 if `step_up` is 0.
- R8: Stepping saturates: a step up at 63 stays at 63, and a step down at 0 stays at 0.
- R9: When several sources act in the same cycle, they win in this order: reset recall, then direct write, then transfer (per-pot or global), then step.
- R10: With no strobe active for a pot, its position holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; recalls slot 0 |
| dr_bank | input | 96 | Stored data registers, 4 slots of 6 bits per pot |
| wr_en | input | 4 | Per-pot direct write strobe |
| wr_data | input | 6 | Value for a direct write |
| xfr_en | input | 4 | Per-pot transfer strobe |
| xfr_all | input | 1 | Global transfer strobe |
| xfr_sel | input | 2 | Data register slot used by transfers |
| step_en | input | 4 | Per-pot single-step strobe |
| step_up | input | 1 | Step direction, 1 = up |
| wiper_pos | output | 24 | Current position of each pot, 6 bits per pot |
| tap_sel | output | 256 | One-hot tap enables, 64 bits per pot |

## Verification
The bench drives every pot to code 63 and steps it up, and drives it to code 0 and steps it down. A counter that wraps instead of saturating would jump to the opposite end of the ladder. It also fires write, transfer and step together, where a wrong priority order would show as the transfer or step value in place of the written one. It runs global transfers with per-pot writes mixed in, which catches a global load that overrides a write or misses one pot. A tap select that is combinational, off by one bit, or reversed shows up against a one-cycle-delayed reference model. A reset in mid-run with new slot-0 contents confirms that the recall takes the current stored value and not a constant.

// File: rtl/wiper_tap_reg.sv
module wiper_tap_reg #(
  parameter int POTS  = 4,
  parameter int WIDTH = 6,
  parameter int REGS  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [POTS*REGS*WIDTH-1:0]    dr_bank,
  input  logic [POTS-1:0]               wr_en,
  input  logic [WIDTH-1:0]              wr_data,
  input  logic [POTS-1:0]               xfr_en,
  input  logic                          xfr_all,
  input  logic [$clog2(REGS)-1:0]       xfr_sel,
  input  logic [POTS-1:0]               step_en,
  input  logic                          step_up,
  output logic [POTS*WIDTH-1:0]         wiper_pos,
  output logic [POTS*(1<<WIDTH)-1:0]    tap_sel
);
  localparam int TAPS = 1 << WIDTH;
  localparam logic [TAPS-1:0] ONE = TAPS'(1);

  for (genvar p = 0; p < POTS; p++) begin : g_pot
    logic [WIDTH-1:0] cnt;
    logic [WIDTH-1:0] recall;
    logic [WIDTH-1:0] xfr_val;
    logic [TAPS-1:0]  tap_q;

    assign recall  = dr_bank[(p*REGS)*WIDTH +: WIDTH];
    assign xfr_val = dr_bank[(p*REGS + int'(xfr_sel))*WIDTH +: WIDTH];

    always_ff @(posedge clk) begin
      if (!rst_n)                    cnt <= recall;
      else if (wr_en[p])             cnt <= wr_data;
      else if (xfr_en[p] || xfr_all) cnt <= xfr_val;
      else if (step_en[p]) begin
        if (step_up && !(&cnt))      cnt <= cnt + 1'b1;
        else if (!step_up && |cnt)   cnt <= cnt - 1'b1;
      end
    end

    always_ff @(posedge clk)
      tap_q <= ONE << (rst_n ? cnt : recall);

    assign wiper_pos[p*WIDTH +: WIDTH] = cnt;
    assign tap_sel[p*TAPS +: TAPS]     = tap_q;
  end
endmodule

module wiper_tap_reg_chk #(
  parameter int POTS  = 4,
  parameter int WIDTH = 6,
  parameter int REGS  = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [POTS*REGS*WIDTH-1:0] dr_bank,
  input logic [POTS-1:0]            wr_en,
  input logic [WIDTH-1:0]           wr_data,
  input logic [POTS-1:0]            xfr_en,
  input logic                       xfr_all,
  input logic [POTS-1:0]            step_en,
  input logic                       step_up,
  input logic [POTS*WIDTH-1:0]      wiper_pos,
  input logic [POTS*(1<<WIDTH)-1:0] tap_sel
);
  localparam int TAPS = 1 << WIDTH;
  localparam logic [TAPS-1:0] ONE = TAPS'(1);
  localparam logic [WIDTH-1:0] TOP = '1;

  for (genvar p = 0; p < POTS; p++) begin : g_chk
    // R2
    tap_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(tap_sel[p*TAPS +: TAPS]) == 1);
    // R3
    tap_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> tap_sel[p*TAPS +: TAPS] == (ONE << $past(wiper_pos[p*WIDTH +: WIDTH])));
    // R4
    direct_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[p] |=> wiper_pos[p*WIDTH +: WIDTH] == $past(wr_data));
    // R8
    top_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en[p] && !xfr_en[p] && !xfr_all && step_en[p] && step_up &&
       wiper_pos[p*WIDTH +: WIDTH] == TOP) |=> wiper_pos[p*WIDTH +: WIDTH] == TOP);
    // R8
    bottom_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en[p] && !xfr_en[p] && !xfr_all && step_en[p] && !step_up &&
       wiper_pos[p*WIDTH +: WIDTH] == '0) |=> wiper_pos[p*WIDTH +: WIDTH] == '0);
    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en[p] && !xfr_en[p] && !xfr_all && !step_en[p]) |=> $stable(wiper_pos[p*WIDTH +: WIDTH]));
  end
endmodule

bind wiper_tap_reg wiper_tap_reg_chk #(.POTS(POTS), .WIDTH(WIDTH), .REGS(REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .dr_bank(dr_bank), .wr_en(wr_en), .wr_data(wr_data),
  .xfr_en(xfr_en), .xfr_all(xfr_all), .step_en(step_en), .step_up(step_up),
  .wiper_pos(wiper_pos), .tap_sel(tap_sel));

// File: tb/wiper_tap_reg_test.sv
module wiper_tap_reg_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [95:0] dr_bank;
  logic [3:0]  wr_en = 0, xfr_en = 0, step_en = 0;
  logic [5:0]  wr_data = 0;
  logic        xfr_all = 0, step_up = 0;
  logic [1:0]  xfr_sel = 0;
  logic [23:0] wiper_pos;
  logic [255:0] tap_sel;

  logic [5:0] dr [4][4];
  logic [5:0] mdl [4];
  logic [5:0] prv [4];
  logic       prev_rst;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  always_comb
    for (int p = 0; p < 4; p++)
      for (int r = 0; r < 4; r++)
        dr_bank[(p*4+r)*6 +: 6] = dr[p][r];

  wiper_tap_reg uut (
    .clk(clk), .rst_n(rst_n), .dr_bank(dr_bank), .wr_en(wr_en), .wr_data(wr_data),
    .xfr_en(xfr_en), .xfr_all(xfr_all), .xfr_sel(xfr_sel), .step_en(step_en),
    .step_up(step_up), .wiper_pos(wiper_pos), .tap_sel(tap_sel));

  function automatic logic [63:0] onehot(input logic [5:0] v);
    return 64'd1 << v;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    logic [5:0] nxt [4];
    string tag [4];
    logic was_rst;
    was_rst = !rst_n;
    for (int p = 0; p < 4; p++) begin
      int n;
      n = int'(wr_en[p]) + int'(xfr_en[p] | xfr_all) + int'(step_en[p]);
      nxt[p] = mdl[p];
      tag[p] = "R10";
      if (!rst_n) begin nxt[p] = dr[p][0]; tag[p] = "R1"; end
      else if (wr_en[p]) begin nxt[p] = wr_data; tag[p] = "R4"; end
      else if (xfr_en[p] || xfr_all) begin
        nxt[p] = dr[p][xfr_sel]; tag[p] = xfr_all ? "R6" : "R5";
      end else if (step_en[p]) begin
        tag[p] = "R7";
        if (step_up) begin
          if (mdl[p] == 6'd63) tag[p] = "R8"; else nxt[p] = mdl[p] + 6'd1;
        end else begin
          if (mdl[p] == 6'd0) tag[p] = "R8"; else nxt[p] = mdl[p] - 6'd1;
        end
      end
      if (rst_n && n > 1) tag[p] = "R9";
    end
    @(posedge clk);
    @(negedge clk);
    for (int p = 0; p < 4; p++) begin
      prv[p] = mdl[p];
      mdl[p] = nxt[p];
      check(tag[p], 64'(wiper_pos[p*6 +: 6]), 64'(mdl[p]));
      if (was_rst) check("R1", tap_sel[p*64 +: 64], onehot(mdl[p]));
      else         check("R3", tap_sel[p*64 +: 64], onehot(prv[p]));
      check("R2", 64'($countones(tap_sel[p*64 +: 64])), 64'd1);
    end
  endtask

  task automatic idle();
    wr_en = 0; xfr_en = 0; xfr_all = 0; step_en = 0;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0;
    repeat (3) cyc();
    rst_n = 1;
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int p = 0; p < 4; p++)
      for (int r = 0; r < 4; r++) dr[p][r] = 6'($urandom);
    dr[0][0] = 6'd0; dr[1][0] = 6'd63;
    @(negedge clk);
    do_reset();

    // R10: idle hold
    repeat (2) cyc();

    // R8: top saturation, R3 high-end code
    wr_en = 4'hF; wr_data = 6'd63; cyc();
    idle(); step_en = 4'hF; step_up = 1; repeat (2) cyc();
    // R7 down then R8 bottom saturation
    idle(); step_en = 4'hF; step_up = 0; cyc();
    wr_en = 4'hF; wr_data = 6'd0; step_en = 0; cyc();
    idle(); step_en = 4'hF; step_up = 0; repeat (2) cyc();

    // R9: all sources together, write wins on pots 0/1, transfer on 2
    wr_en = 4'b0011; wr_data = 6'd21; xfr_en = 4'b0111; xfr_sel = 2'd2;
    step_en = 4'hF; step_up = 1; cyc();
    idle();

    // R6: global transfer, with a write on pot 3 winning
    xfr_all = 1; xfr_sel = 2'd3; wr_en = 4'b1000; wr_data = 6'd9; cyc();
    idle();
    // R5: single-pot transfer from each slot
    for (int s = 0; s < 4; s++) begin
      xfr_en = 4'b0001 << s; xfr_sel = 2'(s); cyc();
    end
    idle();

    for (int i = 0; i < 600; i++) begin
      wr_en   = 4'($urandom) & 4'($urandom);
      wr_data = 6'($urandom);
      xfr_en  = 4'($urandom) & 4'($urandom);
      xfr_all = ($urandom % 8) == 0;
      xfr_sel = 2'($urandom);
      step_en = 4'($urandom);
      step_up = (i / 40) % 2 == 0;
      if (($urandom % 16) == 0)
        dr[$urandom % 4][$urandom % 4] = 6'($urandom);
      cyc();
    end

    // R1: mid-run reset recalls current slot-0 contents
    for (int p = 0; p < 4; p++) dr[p][0] = 6'(7 * p + 40);
    do_reset();
    cyc();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule